// File: doc/BRIEF.md
# Serial Audio FIFO Register Interface

This block is the host-facing front end of a stereo serial audio port. A host reaches it over a simple 32-bit register bus with one-cycle read and write strobes. Five word registers are decoded: control, status, interrupt mask, error clear and a data port. The data port is shared by both directions. A write to it queues a 32-bit stereo word for playback. A read from it takes the oldest captured word from the record queue.

On the other side, a serializer asks for one playback word per frame with a request strobe. It hands over one captured word per frame with a valid strobe. Queue levels are compared against two 4-bit thresholds to raise service requests. These requests serve as DMA triggers and as interrupt sources. A capture that arrives with the record queue full raises a sticky overrun error. A request that finds the playback queue empty raises a sticky underrun error. Both errors stay set until the host writes ones to the clear register. A soft-reset bit in the control register empties both queues and drops the errors.

Register word index (address bits 4:2): 0 control, 1 status, 2 mask, 3 clear, 4 data. Read data appears on the cycle after the read strobe.

Top module: `saf_audio_regs`

## Requirements
- R1: After reset, status reads 0x81, control reads 0 and the interrupt output is low.
- R2: Data-port writes queue words. Each serializer request while the link is on (control bit 0 set, control bit 3 clear) presents the next word on the playback output, in write order.
- R3: The playback queue holds 16 words. A data write while it is full is discarded.
- R4: Data-port reads return captured words in arrival order. A read of an empty record queue returns zero.
- R5: A capture arriving while the record queue holds 16 words is discarded and sets status bit 6 (overrun), which stays set.
- R6: A request that finds the playback queue empty sets status bit 5 (underrun) and leaves the previous word on the playback output.
- R7: Writing a one to clear-register bit 6 clears only the overrun flag. Writing a one to bit 5 clears only the underrun flag.
- R8: Status bit 4 (record service, also the record DMA request) is set when the link is on and the record level is nonzero and at least control bits 15:12.
- R9: Status bit 3 (playback service, also the playback DMA request) is set when the link is on and the playback level is at most control bits 11:8.
- R10: The interrupt output is the OR over status bits 6 to 3, each ANDed with the same-numbered mask bit.
- R11: While control bit 3 is set, both queues are empty, errors are clear, and data-port writes are dropped.
- R12: While control bit 0 is clear, status bit 7 is set, serializer strobes are ignored and both service requests are low.
- R13: Status bit 2 means link on and playback queue not empty. Bit 1 means record queue not empty. Bit 0 means playback queue not full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 5 | Byte address, word index in bits 4:2 |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after the strobe |
| irq | output | 1 | Masked interrupt |
| dreq_rx | output | 1 | Record service / DMA request |
| dreq_tx | output | 1 | Playback service / DMA request |
| ser_tx_req | input | 1 | Serializer asks for a playback word |
| ser_tx_word | output | 32 | Current playback word |
| ser_rx_valid | input | 1 | Serializer delivers a captured word |
| ser_rx_word | input | 32 | Captured word |

## Verification
The bench fills each queue one entry past its depth. A design that let the extra entry in would return word 16 instead of repeating word 15, or would wrap and read back an old word. It also drains the playback queue to underrun. A design that zeroed or advanced the playback word there would show up on the serializer output. The clear register is checked one bit at a time with both errors pending, which catches a design that clears both flags together. Soft reset and link-off are each followed by traffic on the serial side. A design that kept stale data or moved a queue while the link was off would return a wrong word when the link comes back.

// File: rtl/saf_pkg.sv
package saf_pkg;
  localparam int BUS_AW = 5;
  localparam logic [2:0] IDX_CTRL = 3'd0;
  localparam logic [2:0] IDX_STAT = 3'd1;
  localparam logic [2:0] IDX_MASK = 3'd2;
  localparam logic [2:0] IDX_CLR  = 3'd3;
  localparam logic [2:0] IDX_DATA = 3'd4;

  typedef struct packed {
    logic [3:0] rx_th;
    logic [3:0] tx_th;
    logic       srst;
    logic       en;
  } ctrl_t;
endpackage

// File: rtl/saf_fifo.sv
module saf_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       clr,
  input  logic                       push,
  input  logic [DW-1:0]              din,
  input  logic                       pop,
  output logic [DW-1:0]              dout,
  output logic [$clog2(DEPTH):0]     level,
  output logic                       full,
  output logic                       empty
);
  localparam int PW = $clog2(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [PW:0]   wp, rp;

  // storage without reset so it maps onto block RAM
  always_ff @(posedge clk) begin
    if (push) mem[wp[PW-1:0]] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) dout <= '0;
    else if (pop) dout <= mem[rp[PW-1:0]];
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wp <= '0;
      rp <= '0;
    end else begin
      if (push) wp <= wp + 1'b1;
      if (pop)  rp <= rp + 1'b1;
    end
  end

  assign level = wp - rp;
  assign full  = (level == (PW+1)'(DEPTH));
  assign empty = (level == '0);

  // R3: the owner never pushes into a full queue
  a_r3_no_push_full: assert property (@(posedge clk) disable iff (rst) push |-> !full);
  // R4: the owner never pops an empty queue
  a_r4_no_pop_empty: assert property (@(posedge clk) disable iff (rst) pop |-> !empty);
endmodule

// File: rtl/saf_flags.sv
module saf_flags #(
  parameter int LW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          link_on,
  input  logic          srst,
  input  logic [LW-1:0] rx_lvl,
  input  logic [LW-1:0] tx_lvl,
  input  logic [3:0]    rx_th,
  input  logic [3:0]    tx_th,
  input  logic          ovf_evt,
  input  logic          udf_evt,
  input  logic          clr_ror,
  input  logic          clr_tur,
  input  logic [3:0]    mask,     // {ror, tur, rx svc, tx svc}
  output logic          ror,
  output logic          tur,
  output logic          rx_svc,
  output logic          tx_svc,
  output logic          irq
);
  always_ff @(posedge clk) begin
    if (rst || srst) begin
      ror <= 1'b0;
      tur <= 1'b0;
    end else begin
      if (ovf_evt)      ror <= 1'b1;
      else if (clr_ror) ror <= 1'b0;
      if (udf_evt)      tur <= 1'b1;
      else if (clr_tur) tur <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_svc <= 1'b0;
      tx_svc <= 1'b0;
      irq    <= 1'b0;
    end else begin
      rx_svc <= link_on && (rx_lvl != '0) && (rx_lvl >= LW'(rx_th));
      tx_svc <= link_on && (tx_lvl <= LW'(tx_th));
      irq    <= |({ror, tur, rx_svc, tx_svc} & mask);
    end
  end

  // R5: overrun stays until cleared or soft reset
  a_r5_ror_sticky: assert property (@(posedge clk) disable iff (rst)
    (ror && !clr_ror && !srst) |=> ror);
  // R7: a clear with no new overrun drops the flag
  a_r7_clear_ror: assert property (@(posedge clk) disable iff (rst)
    (clr_ror && !ovf_evt) |=> !ror);
  // R10: nothing masked in, no interrupt
  a_r10_irq_masked: assert property (@(posedge clk) disable iff (rst)
    (mask == 4'b0) |=> !irq);
endmodule

// File: rtl/saf_audio_regs.sv
module saf_audio_regs
  import saf_pkg::*;
#(
  parameter int DW    = 32,
  parameter int DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq,
  output logic              dreq_rx,
  output logic              dreq_tx,
  input  logic              ser_tx_req,
  output logic [DW-1:0]     ser_tx_word,
  input  logic              ser_rx_valid,
  input  logic [DW-1:0]     ser_rx_word
);
  localparam int LW = $clog2(DEPTH) + 1;

  ctrl_t       ctrl_q;
  logic [3:0]  mask_q;
  logic [2:0]  idx;
  logic        link_on;
  logic        tx_push, tx_pop, rx_push, rx_pop, ovf_evt, udf_evt;
  logic        tx_full, tx_empty, rx_full, rx_empty;
  logic [LW-1:0] tx_lvl, rx_lvl;
  logic [DW-1:0] rx_q;
  logic        ror, tur, rx_svc, tx_svc;
  logic [7:0]  stat;
  logic [31:0] reg_q;
  logic        data_sel_q, zero_q;
  logic        unused_ok;

  assign idx       = bus_addr[4:2];
  assign unused_ok = ^{bus_addr[1:0], bus_wdata[31:16], bus_wdata[7], bus_wdata[2:1]};
  assign link_on   = ctrl_q.en && !ctrl_q.srst;

  assign tx_push = bus_wr && idx == IDX_DATA && !tx_full && !ctrl_q.srst;
  assign rx_pop  = bus_rd && idx == IDX_DATA && !rx_empty && !ctrl_q.srst;
  assign tx_pop  = link_on && ser_tx_req && !tx_empty;
  assign udf_evt = link_on && ser_tx_req && tx_empty;
  assign rx_push = link_on && ser_rx_valid && !rx_full;
  assign ovf_evt = link_on && ser_rx_valid && rx_full;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      mask_q <= '0;
    end else if (bus_wr) begin
      if (idx == IDX_CTRL)
        ctrl_q <= '{rx_th: bus_wdata[15:12], tx_th: bus_wdata[11:8],
                    srst: bus_wdata[3], en: bus_wdata[0]};
      if (idx == IDX_MASK) mask_q <= bus_wdata[6:3];
    end
  end

  saf_fifo #(.DW(DW), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst(rst), .clr(ctrl_q.srst), .push(tx_push), .din(bus_wdata[DW-1:0]),
    .pop(tx_pop), .dout(ser_tx_word), .level(tx_lvl), .full(tx_full), .empty(tx_empty));

  saf_fifo #(.DW(DW), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst(rst), .clr(ctrl_q.srst), .push(rx_push), .din(ser_rx_word),
    .pop(rx_pop), .dout(rx_q), .level(rx_lvl), .full(rx_full), .empty(rx_empty));

  saf_flags #(.LW(LW)) u_flags (
    .clk(clk), .rst(rst), .link_on(link_on), .srst(ctrl_q.srst),
    .rx_lvl(rx_lvl), .tx_lvl(tx_lvl), .rx_th(ctrl_q.rx_th), .tx_th(ctrl_q.tx_th),
    .ovf_evt(ovf_evt), .udf_evt(udf_evt),
    .clr_ror(bus_wr && idx == IDX_CLR && bus_wdata[6]),
    .clr_tur(bus_wr && idx == IDX_CLR && bus_wdata[5]),
    .mask(mask_q), .ror(ror), .tur(tur), .rx_svc(rx_svc), .tx_svc(tx_svc), .irq(irq));

  assign stat = {!ctrl_q.en, ror, tur, rx_svc, tx_svc,
                 link_on && !tx_empty, !rx_empty, !tx_full};

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_q      <= '0;
      data_sel_q <= 1'b0;
      zero_q     <= 1'b0;
    end else if (bus_rd) begin
      data_sel_q <= (idx == IDX_DATA);
      zero_q     <= !rx_pop;
      case (idx)
        IDX_CTRL: reg_q <= {16'b0, ctrl_q.rx_th, ctrl_q.tx_th, 4'b0, ctrl_q.srst, 2'b0, ctrl_q.en};
        IDX_STAT: reg_q <= {24'b0, stat};
        IDX_MASK: reg_q <= {25'b0, mask_q, 3'b0};
        default:  reg_q <= '0;
      endcase
    end
  end

  assign bus_rdata = data_sel_q ? (zero_q ? 32'b0 : 32'(rx_q)) : reg_q;
  assign dreq_rx   = rx_svc;
  assign dreq_tx   = tx_svc;

  // R11: soft reset leaves both queues empty
  a_r11_srst_empties: assert property (@(posedge clk) disable iff (rst)
    ctrl_q.srst |=> (rx_empty && tx_empty));
  // R6: an underrun repeats the previous playback word
  a_r6_word_held: assert property (@(posedge clk) disable iff (rst)
    udf_evt |=> $stable(ser_tx_word));
  // R12: with the link off, only host writes move the playback queue
  a_r12_off_frozen: assert property (@(posedge clk) disable iff (rst)
    (!link_on && !tx_push && !ctrl_q.srst) |=> $stable(tx_lvl));
endmodule

// File: tb/saf_audio_regs_tb.sv
module saf_audio_regs_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq, dreq_rx, dreq_tx;
  logic        ser_tx_req = 1'b0, ser_rx_valid = 1'b0;
  logic [31:0] ser_tx_word, ser_rx_word = '0;
  int n_chk = 0, n_fail = 0;

  localparam logic [4:0] A_CTRL = 5'h00, A_STAT = 5'h04, A_MASK = 5'h08,
                         A_CLR = 5'h0C, A_DATA = 5'h10;

  always #2.5 clk = ~clk;

  saf_audio_regs u_dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .dreq_rx(dreq_rx),
    .dreq_tx(dreq_tx), .ser_tx_req(ser_tx_req), .ser_tx_word(ser_tx_word),
    .ser_rx_valid(ser_rx_valid), .ser_rx_word(ser_rx_word));

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic settle(); repeat (3) @(negedge clk); endtask

  task automatic ser_send(input logic [31:0] w);
    @(negedge clk); ser_rx_word = w; ser_rx_valid = 1'b1;
    @(negedge clk); ser_rx_valid = 1'b0;
  endtask

  task automatic ser_pull(output logic [31:0] w);
    @(negedge clk); ser_tx_req = 1'b1;
    @(negedge clk); ser_tx_req = 1'b0; w = ser_tx_word;
  endtask

  task automatic stat_bit(input int b, input logic exp, input string tag);
    logic [31:0] s;
    settle();
    rd(A_STAT, s);
    chk(s[b] === exp, tag, {31'b0, s[b]}, {31'b0, exp});
  endtask

  task automatic fresh(input logic [31:0] cfg);
    wr(A_CTRL, cfg | 32'h8);
    wr(A_CTRL, cfg);
    wr(A_MASK, 0);
    settle();
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(A_STAT, d); chk(d === 32'h81, "R1 status after reset", d, 32'h81);
    rd(A_CTRL, d); chk(d === 32'h0, "R1 control after reset", d, 32'h0);
    chk(irq === 1'b0, "R1 irq after reset", {31'b0, irq}, 0);
  endtask

  task automatic t_tx_order();
    logic [31:0] w;
    fresh(32'h1);
    wr(A_DATA, 32'hA0A0_0001); wr(A_DATA, 32'hB0B0_0002); wr(A_DATA, 32'hC0C0_0003);
    stat_bit(2, 1'b1, "R13 busy with queued words");
    ser_pull(w); chk(w === 32'hA0A0_0001, "R2 first word", w, 32'hA0A0_0001);
    ser_pull(w); chk(w === 32'hB0B0_0002, "R2 second word", w, 32'hB0B0_0002);
    ser_pull(w); chk(w === 32'hC0C0_0003, "R2 third word", w, 32'hC0C0_0003);
    ser_pull(w); chk(w === 32'hC0C0_0003, "R6 word repeated on underrun", w, 32'hC0C0_0003);
    stat_bit(5, 1'b1, "R6 underrun flag set");
    wr(A_CLR, 32'h20);
    stat_bit(5, 1'b0, "R7 underrun cleared");
  endtask

  task automatic t_tx_full();
    logic [31:0] w;
    fresh(32'h1);
    for (int i = 0; i < 17; i++) wr(A_DATA, 32'h100 + i);
    stat_bit(0, 1'b0, "R13 not-full low when full");
    for (int i = 0; i < 16; i++) begin
      ser_pull(w); chk(w === 32'h100 + i, "R3 drained word", w, 32'h100 + i);
    end
    ser_pull(w); chk(w === 32'h10F, "R3 extra write dropped", w, 32'h10F);
  endtask

  task automatic t_rx();
    logic [31:0] d;
    fresh(32'h1);
    ser_send(32'h1111); ser_send(32'h2222); ser_send(32'h3333);
    stat_bit(1, 1'b1, "R13 record not empty");
    rd(A_DATA, d); chk(d === 32'h1111, "R4 first capture", d, 32'h1111);
    rd(A_DATA, d); chk(d === 32'h2222, "R4 second capture", d, 32'h2222);
    rd(A_DATA, d); chk(d === 32'h3333, "R4 third capture", d, 32'h3333);
    rd(A_DATA, d); chk(d === 32'h0, "R4 empty read is zero", d, 32'h0);
  endtask

  task automatic t_ovf();
    logic [31:0] d, w;
    fresh(32'h1);
    for (int i = 0; i < 17; i++) ser_send(32'h500 + i);
    stat_bit(6, 1'b1, "R5 overrun flag set");
    for (int i = 0; i < 16; i++) begin
      rd(A_DATA, d); chk(d === 32'h500 + i, "R5 kept capture", d, 32'h500 + i);
    end
    rd(A_DATA, d); chk(d === 32'h0, "R5 extra capture dropped", d, 32'h0);
    stat_bit(6, 1'b1, "R5 overrun still set after drain");
    ser_pull(w);
    wr(A_CLR, 32'h40);
    stat_bit(6, 1'b0, "R7 overrun cleared alone");
    stat_bit(5, 1'b1, "R7 underrun untouched by bit 6");
    wr(A_CLR, 32'h20);
  endtask

  task automatic t_svc_irq();
    fresh(32'h4201);
    stat_bit(3, 1'b1, "R9 playback service at level 0");
    chk(dreq_tx === 1'b1, "R9 playback request pin", {31'b0, dreq_tx}, 1);
    wr(A_DATA, 1); wr(A_DATA, 2); wr(A_DATA, 3);
    stat_bit(3, 1'b0, "R9 playback service off above threshold");
    ser_send(7); ser_send(8); ser_send(9);
    stat_bit(4, 1'b0, "R8 record service off below threshold");
    ser_send(10);
    stat_bit(4, 1'b1, "R8 record service at threshold");
    chk(dreq_rx === 1'b1, "R8 record request pin", {31'b0, dreq_rx}, 1);
    wr(A_MASK, 32'h10); settle();
    chk(irq === 1'b1, "R10 irq from record service", {31'b0, irq}, 1);
    wr(A_MASK, 32'h08); settle();
    chk(irq === 1'b0, "R10 irq masked to idle source", {31'b0, irq}, 0);
    wr(A_MASK, 32'h40); settle();
    chk(irq === 1'b0, "R10 irq off with no overrun", {31'b0, irq}, 0);
    wr(A_MASK, 0);
  endtask

  task automatic t_srst();
    logic [31:0] d;
    wr(A_CTRL, 32'h4209);
    stat_bit(1, 1'b0, "R11 record empty in soft reset");
    stat_bit(0, 1'b1, "R11 playback not full in soft reset");
    wr(A_DATA, 32'hDEAD);
    wr(A_CTRL, 32'h4201);
    stat_bit(2, 1'b0, "R11 write during soft reset dropped");
    rd(A_DATA, d); chk(d === 32'h0, "R11 record emptied", d, 32'h0);
  endtask

  task automatic t_off();
    logic [31:0] w0, w;
    fresh(32'h0);
    stat_bit(7, 1'b1, "R12 off flag");
    stat_bit(3, 1'b0, "R12 no playback service when off");
    w0 = ser_tx_word;
    wr(A_DATA, 32'hD15A);
    ser_send(32'h7777);
    stat_bit(1, 1'b0, "R12 capture ignored when off");
    ser_pull(w); chk(w === w0, "R12 request ignored when off", w, w0);
    stat_bit(5, 1'b0, "R12 no underrun when off");
    wr(A_CTRL, 32'h1);
    ser_pull(w); chk(w === 32'hD15A, "R12 word kept until link on", w, 32'hD15A);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'h1, 32'h0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_tx_order();
    t_tx_full();
    t_rx();
    t_ovf();
    t_svc_irq();
    t_srst();
    t_off();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule